// File: doc/BRIEF.md
# Segment Access Verification Unit

This block answers one question without ever faulting: may code running at a given current privilege level (CPL) read from, or write to, the segment named by a 16-bit selector? A one-cycle start pulse brings in the selector, the requested check (read or write), the CPL, the processor mode, a lock-prefix flag, and the base and limit of both descriptor tables. The block checks the selector against the limit of its table. It then fetches the 8-byte descriptor as two 32-bit words and judges the descriptor's class, privilege and access rights.

The block finishes with a one-cycle done pulse. The zero flag output `zf_o` then holds the verdict until the next completed probe. A check that fails clears the flag and raises no exception. The only indication the block raises is invalid-opcode, and it does so for two causes: the probe is issued in a mode that does not recognise it, or it carries a lock prefix.

Descriptor words arrive over a valid/ready read port. The request channel may be back-pressured for any number of cycles by holding `mem_req_ready_i` low, and the block keeps the request address steady until it is accepted. The response channel has no ready signal. The block accepts `mem_rsp_valid_i` in any cycle in which it is waiting for a word, and the memory must send exactly one response per accepted request.

Top module: `seg_probe`

## Requirements
- R1: Selector bits 1:0 are the requester privilege level (RPL). Bit 2 selects the local table (1) or the global table (0). Bits 15:3 are the index. The descriptor is read as two words, first at table base + index*8 (low word) and then at that address + 4 (high word).
- R2: When index*8 + 7 exceeds the limit of the selected table, the probe completes with `zf_o` = 0 and issues no memory read.
- R3: A descriptor whose high-word bit 12 (the code/data class bit) is 0 is a system segment and always gives `zf_o` = 0.
- R4: The descriptor privilege level (DPL) is in high-word bits 14:13. For any segment other than a conforming code segment, `zf_o` = 0 when CPL > DPL or when RPL > DPL.
- R5: A conforming code segment skips the privilege comparison. A readable conforming segment passes a read check even at CPL 3 and RPL 3 against DPL 0.
- R6: The type field is high-word bits 11:8. When bit 11 is 1 the segment is code, with bit 10 meaning conforming and bit 9 meaning readable. When bit 11 is 0 the segment is data, and a data segment is always readable. A read check sets `zf_o` only for a readable segment.
- R7: A write check sets `zf_o` only for a data segment whose bit 9 (writable) is 1. A code segment never passes a write check.
- R8: `mode_i` is encoded as 00 protected, 01 real-address, 10 virtual-8086 and 11 64-bit/compatibility. Modes 01 and 10 complete the probe with `ud_o` = 1, issue no memory read and leave `zf_o` unchanged.
- R9: `lock_i` = 1 at start completes the probe with `ud_o` = 1, issues no memory read and leaves `zf_o` unchanged.
- R10: `done_o` is high for exactly one cycle per accepted probe. `zf_o` holds its value between completions and is 0 after reset. A start pulse that arrives while a probe is in progress is ignored.
- R11: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and `mem_req_addr_o` stays stable. Back-pressure on the request channel does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a probe |
| op_write_i | input | 1 | 0 = read check, 1 = write check |
| selector_i | input | 16 | Segment selector to verify |
| cpl_i | input | 2 | Current privilege level |
| mode_i | input | 2 | Processor mode (see R8) |
| lock_i | input | 1 | Lock prefix present on the operation |
| gdt_base_i | input | AW | Global table base address |
| gdt_limit_i | input | LIMW | Global table limit in bytes |
| ldt_base_i | input | AW | Local table base address |
| ldt_limit_i | input | LIMW | Local table limit in bytes |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | AW | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word |
| done_o | output | 1 | Probe complete (one cycle) |
| zf_o | output | 1 | Zero flag verdict |
| ud_o | output | 1 | Invalid-opcode indication, valid with done_o |

## Verification
Some behaviours are checked by assertions on every cycle. The done pulse must last one cycle. The request address must stay stable under back-pressure. A disallowed mode or a lock prefix must lead, one cycle after start, to a done pulse with invalid-opcode and an unchanged flag. An out-of-limit selector must lead to an immediate cleared verdict. Other behaviours can only be shown by the bench's directed scenarios, which compare the verdict against descriptors the bench builds itself. These are the descriptor decoding itself (system class, privilege ordering, the conforming exception, readable and writable bits), the address order of the two fetched words, and the rejection of a start pulse during a busy probe.

// File: rtl/segv_pkg.sv
package segv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LO,
    ST_RSP_LO,
    ST_REQ_HI,
    ST_RSP_HI,
    ST_DONE
  } probe_state_e;

  localparam logic [1:0] MODE_PROT = 2'b00;
  localparam logic [1:0] MODE_REAL = 2'b01;
  localparam logic [1:0] MODE_V86  = 2'b10;
  localparam logic [1:0] MODE_WIDE = 2'b11;

  typedef struct packed {
    logic       is_code;
    logic       conforming;
    logic       rw_bit;
    logic       accessed;
  } seg_kind_t;
endpackage

// File: rtl/segv_gate.sv
module segv_gate #(
  parameter int SELW = 16,
  parameter int LIMW = 16
) (
  input  logic [SELW-1:0] selector_i,
  input  logic [LIMW-1:0] gdt_limit_i,
  input  logic [LIMW-1:0] ldt_limit_i,
  input  logic [1:0]      mode_i,
  input  logic            lock_i,
  output logic [SELW-1:0] offset_o,
  output logic            use_ldt_o,
  output logic            beyond_o,
  output logic            ud_o
);
  import segv_pkg::*;

  localparam int CW = ((SELW > LIMW) ? SELW : LIMW) + 1;

  logic [CW-1:0] last_byte;
  logic [CW-1:0] lim_ext;

  always_comb begin
    offset_o  = {selector_i[SELW-1:3], 3'b000};
    use_ldt_o = selector_i[2];
    last_byte = CW'(offset_o) + CW'(7);
    lim_ext   = use_ldt_o ? CW'(ldt_limit_i) : CW'(gdt_limit_i);
    beyond_o  = last_byte > lim_ext;
    ud_o      = lock_i || (mode_i == MODE_REAL) || (mode_i == MODE_V86);
  end
endmodule

// File: rtl/segv_judge.sv
module segv_judge (
  input  logic [31:0] hi_word_i,
  input  logic        op_write_i,
  input  logic [1:0]  cpl_i,
  input  logic [1:0]  rpl_i,
  output logic        pass_o
);
  import segv_pkg::*;

  seg_kind_t  kind;
  logic       class_bit;
  logic [1:0] dpl;
  logic       readable;
  logic       writable;
  logic       priv_bad;
  logic       unused_bits;

  always_comb begin
    kind      = seg_kind_t'(hi_word_i[11:8]);
    class_bit = hi_word_i[12];
    dpl       = hi_word_i[14:13];
    readable  = kind.is_code ? kind.rw_bit : 1'b1;
    writable  = kind.is_code ? 1'b0 : kind.rw_bit;
    priv_bad  = !(kind.is_code && kind.conforming) &&
                ((cpl_i > dpl) || (rpl_i > dpl));
    pass_o    = class_bit && !priv_bad && (op_write_i ? writable : readable);
  end

  assign unused_bits = ^{hi_word_i[31:15], hi_word_i[7:0], kind.accessed};
endmodule

// File: rtl/seg_probe.sv
module seg_probe #(
  parameter int AW   = 32,
  parameter int LIMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            op_write_i,
  input  logic [15:0]     selector_i,
  input  logic [1:0]      cpl_i,
  input  logic [1:0]      mode_i,
  input  logic            lock_i,
  input  logic [AW-1:0]   gdt_base_i,
  input  logic [LIMW-1:0] gdt_limit_i,
  input  logic [AW-1:0]   ldt_base_i,
  input  logic [LIMW-1:0] ldt_limit_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [AW-1:0]   mem_req_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [31:0]     mem_rsp_data_i,
  output logic            done_o,
  output logic            zf_o,
  output logic            ud_o
);
  import segv_pkg::*;

  localparam int SELW      = 16;
  localparam int WORD_STEP = 4;

  probe_state_e    state_q;
  logic [AW-1:0]   addr_q;
  logic            op_q;
  logic [1:0]      cpl_q;
  logic [1:0]      rpl_q;
  logic            zf_q;
  logic            ud_q;

  logic [SELW-1:0] offset;
  logic            use_ldt;
  logic            beyond;
  logic            ud_now;
  logic            pass;
  logic            idle;

  segv_gate #(.SELW(SELW), .LIMW(LIMW)) u_gate (
    .selector_i (selector_i),
    .gdt_limit_i(gdt_limit_i),
    .ldt_limit_i(ldt_limit_i),
    .mode_i     (mode_i),
    .lock_i     (lock_i),
    .offset_o   (offset),
    .use_ldt_o  (use_ldt),
    .beyond_o   (beyond),
    .ud_o       (ud_now)
  );

  segv_judge u_judge (
    .hi_word_i (mem_rsp_data_i),
    .op_write_i(op_q),
    .cpl_i     (cpl_q),
    .rpl_i     (rpl_q),
    .pass_o    (pass)
  );

  assign idle = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      op_q    <= 1'b0;
      cpl_q   <= 2'b00;
      rpl_q   <= 2'b00;
      zf_q    <= 1'b0;
      ud_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q   <= op_write_i;
            cpl_q  <= cpl_i;
            rpl_q  <= selector_i[1:0];
            addr_q <= (use_ldt ? ldt_base_i : gdt_base_i) + AW'(offset);
            if (ud_now) begin
              ud_q    <= 1'b1;
              state_q <= ST_DONE;
            end else if (beyond) begin
              ud_q    <= 1'b0;
              zf_q    <= 1'b0;
              state_q <= ST_DONE;
            end else begin
              ud_q    <= 1'b0;
              state_q <= ST_REQ_LO;
            end
          end
        end
        ST_REQ_LO: if (mem_req_ready_i) state_q <= ST_RSP_LO;
        ST_RSP_LO: begin
          if (mem_rsp_valid_i) begin
            addr_q  <= addr_q + AW'(WORD_STEP);
            state_q <= ST_REQ_HI;
          end
        end
        ST_REQ_HI: if (mem_req_ready_i) state_q <= ST_RSP_HI;
        ST_RSP_HI: begin
          if (mem_rsp_valid_i) begin
            zf_q    <= pass;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
  assign mem_req_addr_o  = addr_q;
  assign done_o          = (state_q == ST_DONE);
  assign zf_o            = zf_q;
  assign ud_o            = done_o && ud_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  assert_mode_ud_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i && (mode_i == MODE_REAL || mode_i == MODE_V86))
      |=> (done_o && ud_o && $stable(zf_o)));

  assert_lock_ud_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i && lock_i) |=> (done_o && ud_o && $stable(zf_o)));

  assert_limit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i && !ud_now && beyond) |=> (done_o && !ud_o && !zf_o));
endmodule

// File: tb/test_seg_probe.sv
`timescale 1ns/1ps
module test_seg_probe;
  localparam int AW = 32;
  localparam int LIMW = 16;
  localparam logic [31:0] GDT_BASE = 32'h0000_1000;
  localparam logic [31:0] LDT_BASE = 32'h0000_2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic op_write_i = 1'b0;
  logic [15:0] selector_i = '0;
  logic [1:0] cpl_i = '0;
  logic [1:0] mode_i = '0;
  logic lock_i = 1'b0;
  logic [AW-1:0] gdt_base_i = GDT_BASE;
  logic [LIMW-1:0] gdt_limit_i = 16'd127;
  logic [AW-1:0] ldt_base_i = LDT_BASE;
  logic [LIMW-1:0] ldt_limit_i = 16'd63;
  logic mem_req_valid_o;
  logic mem_req_ready_i = 1'b0;
  logic [AW-1:0] mem_req_addr_o;
  logic mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic done_o, zf_o, ud_o;

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  int done_count = 0;
  logic [31:0] addr_prev = '0;
  logic [31:0] addr_last = '0;
  bit stall_en = 0;
  logic [63:0] gdt [0:15];
  logic [63:0] ldt [0:7];
  logic res_zf, res_ud;

  always #2 clk = ~clk;

  seg_probe #(.AW(AW), .LIMW(LIMW)) i_seg_probe (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_write_i(op_write_i),
    .selector_i(selector_i), .cpl_i(cpl_i), .mode_i(mode_i), .lock_i(lock_i),
    .gdt_base_i(gdt_base_i), .gdt_limit_i(gdt_limit_i),
    .ldt_base_i(ldt_base_i), .ldt_limit_i(ldt_limit_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .done_o(done_o), .zf_o(zf_o), .ud_o(ud_o)
  );

  function automatic logic [63:0] mk_desc(logic [3:0] kind, logic cls, logic [1:0] dpl);
    return {8'h00, 4'hC, 4'hF, 1'b1, dpl, cls, kind, 8'h12, 32'h0000_FFFF};
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] rel;
    logic [63:0] d;
    d = 64'h0;
    if (a >= GDT_BASE && a < GDT_BASE + 32'd128) begin
      rel = a - GDT_BASE; d = gdt[rel[6:3]];
    end else if (a >= LDT_BASE && a < LDT_BASE + 32'd64) begin
      rel = a - LDT_BASE; d = ldt[rel[5:3]];
    end
    return a[2] ? d[63:32] : d[31:0];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model
  initial begin
    bit pending = 0;
    bit stalled = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      if (pending) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = mem_word(paddr);
        mem_req_ready_i = 1'b0;
        pending = 0;
      end else if (mem_req_valid_o) begin
        if (stall_en && !stalled) begin
          stalled = 1; mem_req_ready_i = 1'b0;
        end else begin
          stalled = 0; mem_req_ready_i = 1'b1; pending = 1;
          paddr = mem_req_addr_o;
          addr_prev = addr_last; addr_last = mem_req_addr_o;
          req_count++;
        end
      end else begin
        mem_req_ready_i = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (done_o) done_count++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  task automatic probe(bit wr, logic [15:0] sel, logic [1:0] cpl, logic [1:0] mode, bit lock);
    int guard = 0;
    @(negedge clk);
    op_write_i = wr; selector_i = sel; cpl_i = cpl; mode_i = mode; lock_i = lock;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && guard < 200) begin @(negedge clk); guard++; end
    res_zf = zf_o; res_ud = ud_o;
    @(negedge clk);
    chk(!done_o, "R10", "done single cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk(zf_o == 0 && done_o == 0 && ud_o == 0 && mem_req_valid_o == 0, "R10", "reset state",
        {zf_o, done_o, ud_o, mem_req_valid_o}, 0);
  endtask

  task automatic t_data();
    int n0;
    n0 = req_count;
    probe(0, 16'h0008, 0, 2'b00, 0);
    chk(res_zf == 1, "R6", "read rw data", res_zf, 1);
    chk(req_count - n0 == 2, "R1", "two reads", req_count - n0, 2);
    chk(addr_prev == 32'h1008 && addr_last == 32'h100C, "R1", "word order",
        {addr_prev, addr_last}, {32'h1008, 32'h100C});
    probe(1, 16'h0008, 0, 2'b11, 0);
    chk(res_zf == 1 && res_ud == 0, "R7", "write rw data", res_zf, 1);
    probe(1, 16'h0010, 0, 2'b00, 0);
    chk(res_zf == 0, "R7", "write ro data", res_zf, 0);
    probe(0, 16'h0010, 0, 2'b00, 0);
    chk(res_zf == 1, "R6", "read ro data", res_zf, 1);
  endtask

  task automatic t_code();
    probe(0, 16'h0018, 0, 2'b00, 0);
    chk(res_zf == 1, "R6", "read readable code", res_zf, 1);
    probe(1, 16'h0018, 0, 2'b00, 0);
    chk(res_zf == 0, "R7", "write code", res_zf, 0);
    probe(0, 16'h0020, 0, 2'b00, 0);
    chk(res_zf == 0, "R6", "read exec-only code", res_zf, 0);
  endtask

  task automatic t_system();
    probe(0, 16'h0028, 0, 2'b00, 0);
    chk(res_zf == 0, "R3", "system segment", res_zf, 0);
  endtask

  task automatic t_priv();
    probe(0, 16'h0030, 2, 2'b00, 0);
    chk(res_zf == 0, "R4", "cpl above dpl", res_zf, 0);
    probe(0, 16'h0032, 1, 2'b00, 0);
    chk(res_zf == 0, "R4", "rpl above dpl", res_zf, 0);
    probe(0, 16'h0031, 1, 2'b00, 0);
    chk(res_zf == 1, "R4", "equal privilege", res_zf, 1);
  endtask

  task automatic t_conform();
    probe(0, 16'h003B, 3, 2'b00, 0);
    chk(res_zf == 1, "R5", "conforming read at cpl3", res_zf, 1);
    probe(1, 16'h003B, 3, 2'b00, 0);
    chk(res_zf == 0, "R7", "conforming write", res_zf, 0);
  endtask

  task automatic t_limit();
    int n0;
    probe(0, 16'h0078, 0, 2'b00, 0);
    chk(res_zf == 1, "R2", "last gdt entry in limit", res_zf, 1);
    n0 = req_count;
    probe(0, 16'h0080, 0, 2'b00, 0);
    chk(res_zf == 0 && req_count == n0, "R2", "gdt beyond limit", {res_zf, 31'(req_count - n0)}, 0);
    probe(0, 16'h0014, 0, 2'b00, 0);
    chk(res_zf == 1, "R1", "local table read", res_zf, 1);
    chk(addr_prev == 32'h2010, "R1", "local table address", addr_prev, 32'h2010);
    n0 = req_count;
    probe(0, 16'h0044, 0, 2'b00, 0);
    chk(res_zf == 0 && req_count == n0, "R2", "ldt beyond limit", res_zf, 0);
  endtask

  task automatic t_ud();
    int n0;
    probe(0, 16'h0008, 0, 2'b00, 0);
    chk(res_zf == 1, "R8", "preset flag", res_zf, 1);
    n0 = req_count;
    probe(0, 16'h0028, 0, 2'b01, 0);
    chk(res_ud == 1 && res_zf == 1 && req_count == n0, "R8", "real mode", {res_ud, res_zf}, 2'b11);
    probe(0, 16'h0028, 0, 2'b10, 0);
    chk(res_ud == 1 && res_zf == 1 && req_count == n0, "R8", "v86 mode", {res_ud, res_zf}, 2'b11);
    probe(0, 16'h0028, 0, 2'b00, 1);
    chk(res_ud == 1 && res_zf == 1 && req_count == n0, "R9", "lock prefix", {res_ud, res_zf}, 2'b11);
  endtask

  task automatic t_busy();
    int n0, d0, guard;
    stall_en = 1;
    n0 = req_count; d0 = done_count; guard = 0;
    @(negedge clk);
    op_write_i = 0; selector_i = 16'h0028; cpl_i = 0; mode_i = 0; lock_i = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    op_write_i = 1; selector_i = 16'h0008; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && guard < 200) begin @(negedge clk); guard++; end
    res_zf = zf_o;
    repeat (12) @(negedge clk);
    stall_en = 0;
    chk(res_zf == 0, "R11", "result under back-pressure", res_zf, 0);
    chk(req_count - n0 == 2, "R10", "busy start ignored (reads)", req_count - n0, 2);
    chk(done_count - d0 == 1, "R10", "busy start ignored (done)", done_count - d0, 1);
    chk(zf_o == 0, "R10", "flag held", zf_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) gdt[i] = mk_desc(4'b0010, 1'b1, 2'd0);
    for (int i = 0; i < 8; i++) ldt[i] = mk_desc(4'b0010, 1'b1, 2'd0);
    gdt[1] = mk_desc(4'b0010, 1'b1, 2'd0);
    gdt[2] = mk_desc(4'b0000, 1'b1, 2'd0);
    gdt[3] = mk_desc(4'b1010, 1'b1, 2'd0);
    gdt[4] = mk_desc(4'b1000, 1'b1, 2'd0);
    gdt[5] = mk_desc(4'b0010, 1'b0, 2'd3);
    gdt[6] = mk_desc(4'b0010, 1'b1, 2'd1);
    gdt[7] = mk_desc(4'b1110, 1'b1, 2'd0);
    gdt[15] = mk_desc(4'b0000, 1'b1, 2'd3);
    ldt[2] = mk_desc(4'b0000, 1'b1, 2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_code();
    t_system();
    t_priv();
    t_conform();
    t_limit();
    t_ud();
    t_busy();
    finish_run();
  end
endmodule